// File: doc/BRIEF.md
# Parallel port register interface

This block is the host-facing register file of a PC-style parallel port. A byte-wide synchronous host bus reads and writes a small window of byte offsets. Behind that window sit a latched data byte, a control byte that drives the cable control lines and sets the direction of the data lines, a view of the sampled status lines, and two EPP locations. Each EPP location turns a host access into a single-cycle strobe with the byte attached. An acknowledge event from the cable can raise a level interrupt request. A read of the status location drops that request.

The host bus has no back-pressure. The block accepts one access per cycle, and the host asserts at most one of the write or read strobes in a cycle. Read data comes back registered: it is marked by `host_rvalid` in the cycle after the read strobe. That valid flag is a one-cycle pulse with no ready, so the host must take the byte in that cycle. The EPP strobes and `epp_wbyte` follow the same rule: each strobe is a one-cycle valid pulse with no acceptance signal. At the default base, eight offsets are decoded. When the block is built for base 0x3BC, only offsets 0 to 3 are decoded.

Top module: `pp_regif`

## Requirements
- R1: After reset, `ctl_lines` is 8'hC0, `pd_reverse` is 0 (forward), `irq` is 0, `pd_out` and the data register are 8'h00, and `host_rvalid` is 0.
- R2: Every read strobe gives `host_rvalid` = 1 in the next cycle, with the result on `host_rdata`. At offsets 5, 6 and 7, a read returns 8'hFF and a write changes no output.
- R3: A write to offset 0 latches the byte into the data register, and `pd_out` drives it from the next cycle. In forward mode, a read of offset 0 returns the latched byte.
- R4: In reverse mode, a read of offset 0 returns `pd_in` as sampled in the strobe cycle and also loads that byte into the data register. `pd_out` then shows it, and later forward reads return it.
- R5: A control write (offset 2) first sets bits 7:6 of the byte to one. If the result differs from the stored control byte, bit 5 of the result sets `pd_reverse` (1 = reverse/input). The result is then stored with bit 5 cleared and driven on `ctl_lines`. A read of offset 2 returns the stored byte.
- R6: A control write whose forced value equals the stored control byte changes nothing, including `pd_reverse`.
- R7: A read of offset 1 returns `status_in` as sampled in the strobe cycle, and `irq` is 0 from the next cycle.
- R8: `ack_evt` sets `irq` in the next cycle only while stored control bit 4 is 1. Otherwise the event is ignored. If an enabled event and a status read fall in the same cycle, the event wins.
- R9: A write to offset 3 gives a one-cycle `epp_addr_wr` pulse in the next cycle. A write to offset 4 gives a one-cycle `epp_data_wr` pulse instead. In both cases `epp_wbyte` holds the written byte.
- R10: A read of offset 3 gives a one-cycle `epp_addr_rd` pulse, and a read of offset 4 gives `epp_data_rd`. Each returns `pd_in` as sampled in the strobe cycle.
- R11: With `BASE_ADDR` = 16'h3BC, offsets 4 to 7 are undecoded. Writes there give no pulse, and reads return 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Byte offset inside the register window |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read-data valid |
| pd_out | output | 8 | Data register driven toward the cable |
| pd_in | input | 8 | Data lines sampled from the cable |
| pd_reverse | output | 1 | Data-line direction, 1 = input |
| ctl_lines | output | 8 | Stored control byte |
| status_in | input | 8 | Status lines from the cable |
| ack_evt | input | 1 | Acknowledge event, one cycle per event |
| irq | output | 1 | Level interrupt request |
| epp_addr_wr | output | 1 | EPP address write strobe |
| epp_data_wr | output | 1 | EPP data write strobe |
| epp_addr_rd | output | 1 | EPP address read strobe |
| epp_data_rd | output | 1 | EPP data read strobe |
| epp_wbyte | output | 8 | Byte carried by EPP write strobes |

## Verification
If the stored control byte is corrupted, the fault shows on `ctl_lines` in the cycle after the write. A direction bit that is not cleared before storage would show up there as bit 5 set. A wrong direction state shows on `pd_reverse` at once, and on the first data read, which returns the latch instead of `pd_in` or the reverse. A stuck or lost interrupt shows on `irq` one cycle after the acknowledge or status read. The full sweep of all 256 control bytes covers every case of the compare-then-store rule, both the writes that take effect and those that leave the byte unchanged.

// File: rtl/pp_regif_pkg.sv
`timescale 1ns/1ps
package pp_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTL  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_EPPA = 3'd3;
  localparam logic [OFS_W-1:0] OFS_EPPD = 3'd4;

  localparam int CTL_DIR_BIT   = 5;
  localparam int CTL_ACKIE_BIT = 4;
  localparam logic [BYTE_W-1:0] CTL_FIXED    = 8'hC0;
  localparam logic [BYTE_W-1:0] CTL_DIR_MASK = 8'h20;
  localparam logic [BYTE_W-1:0] HOLE_BYTE    = 8'hFF;
  localparam logic [15:0]       NARROW_BASE  = 16'h3BC;

  typedef struct packed {
    logic data;
    logic ctl;
    logic eppa;
    logic eppd;
  } wsel_t;

  typedef struct packed {
    logic data;
    logic stat;
    logic ctl;
    logic eppa;
    logic eppd;
  } rsel_t;
endpackage

// File: rtl/pp_addr_dec.sv
`timescale 1ns/1ps
module pp_addr_dec
  import pp_regif_pkg::*;
#(
  parameter int NUM_OFFS = 8
) (
  input  logic [OFS_W-1:0] addr,
  input  logic             wr,
  input  logic             rd,
  output wsel_t            wsel,
  output rsel_t            rsel
);
  logic hit;
  assign hit = (int'(addr) < NUM_OFFS);

  always_comb begin
    wsel = '0;
    rsel = '0;
    if (hit) begin
      case (addr)
        OFS_DATA: begin wsel.data = wr; rsel.data = rd; end
        OFS_STAT: rsel.stat = rd;
        OFS_CTL:  begin wsel.ctl  = wr; rsel.ctl  = rd; end
        OFS_EPPA: begin wsel.eppa = wr; rsel.eppa = rd; end
        OFS_EPPD: begin wsel.eppd = wr; rsel.eppd = rd; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pp_ctl_reg.sv
`timescale 1ns/1ps
module pp_ctl_reg
  import pp_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              reverse_q
);
  logic [BYTE_W-1:0] forced;
  logic              differs;

  assign forced  = wdata | CTL_FIXED;
  assign differs = (forced != ctl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= CTL_FIXED;
      reverse_q <= 1'b0;
    end else if (wr_en && differs) begin
      reverse_q <= forced[CTL_DIR_BIT];
      ctl_q     <= forced & ~CTL_DIR_MASK;
    end
  end
endmodule

// File: rtl/pp_irq.sv
`timescale 1ns/1ps
module pp_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_evt,
  input  logic enable,
  input  logic clear,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (ack_evt && enable) irq_q <= 1'b1;
    else if (clear)            irq_q <= 1'b0;
  end
endmodule

// File: rtl/pp_regif.sv
`timescale 1ns/1ps
module pp_regif
  import pp_regif_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h378
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [BYTE_W-1:0] pd_out,
  input  logic [BYTE_W-1:0] pd_in,
  output logic              pd_reverse,
  output logic [BYTE_W-1:0] ctl_lines,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              ack_evt,
  output logic              irq,
  output logic              epp_addr_wr,
  output logic              epp_data_wr,
  output logic              epp_addr_rd,
  output logic              epp_data_rd,
  output logic [BYTE_W-1:0] epp_wbyte
);
  localparam int NUM_OFFS = (BASE_ADDR == NARROW_BASE) ? 4 : 8;

  wsel_t             wsel;
  rsel_t             rsel;
  logic [BYTE_W-1:0] ctl_q;
  logic              rev_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] epp_byte_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [3:0]        pulse_q;
  logic [BYTE_W-1:0] rd_mux;

  pp_addr_dec #(.NUM_OFFS(NUM_OFFS)) u_dec (
    .addr (host_addr),
    .wr   (host_wr),
    .rd   (host_rd),
    .wsel (wsel),
    .rsel (rsel)
  );

  pp_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wsel.ctl),
    .wdata     (host_wdata),
    .ctl_q     (ctl_q),
    .reverse_q (rev_q)
  );

  pp_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_evt (ack_evt),
    .enable  (ctl_q[CTL_ACKIE_BIT]),
    .clear   (rsel.stat),
    .irq_q   (irq)
  );

  always_comb begin
    rd_mux = HOLE_BYTE;
    if (rsel.data)                   rd_mux = rev_q ? pd_in : data_q;
    else if (rsel.stat)              rd_mux = status_in;
    else if (rsel.ctl)               rd_mux = ctl_q | CTL_FIXED;
    else if (rsel.eppa || rsel.eppd) rd_mux = pd_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      epp_byte_q <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      pulse_q    <= '0;
    end else begin
      rvalid_q <= host_rd;
      if (host_rd) rdata_q <= rd_mux;
      if (wsel.data)                data_q <= host_wdata;
      else if (rsel.data && rev_q)  data_q <= pd_in;
      if (wsel.eppa || wsel.eppd)   epp_byte_q <= host_wdata;
      pulse_q <= {wsel.eppa, wsel.eppd, rsel.eppa, rsel.eppd};
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign pd_out      = data_q;
  assign pd_reverse  = rev_q;
  assign ctl_lines   = ctl_q;
  assign epp_wbyte   = epp_byte_q;
  assign epp_addr_wr = pulse_q[3];
  assign epp_data_wr = pulse_q[2];
  assign epp_addr_rd = pulse_q[1];
  assign epp_data_rd = pulse_q[0];
endmodule

// File: rtl/pp_regif_chk.sv
`timescale 1ns/1ps
module pp_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_rvalid,
  input logic       pd_reverse,
  input logic [7:0] ctl_lines,
  input logic       ack_evt,
  input logic       irq,
  input logic       epp_addr_wr,
  input logic       epp_data_wr,
  input logic       epp_addr_rd,
  input logic       epp_data_rd
);
  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R5
  ctl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lines[7:6] == 2'b11) && !ctl_lines[5]);

  // R6
  dir_only_on_ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_reverse) |-> $past(host_wr && host_addr == 3'd2));

  // R7
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd1 && !ack_evt) |=> !irq);

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_evt && ctl_lines[4]));

  // R9
  epp_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({epp_addr_wr, epp_data_wr, epp_addr_rd, epp_data_rd}));
endmodule

bind pp_regif pp_regif_chk u_chk (.*);

// File: tb/pp_regif_bench.sv
`timescale 1ns/1ps
module pp_regif_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] pd_in = '0;
  logic [7:0] status_in = '0;
  logic       ack_evt = 1'b0;

  logic [7:0] host_rdata, pd_out, ctl_lines, epp_wbyte;
  logic       host_rvalid, pd_reverse, irq;
  logic       epp_addr_wr, epp_data_wr, epp_addr_rd, epp_data_rd;

  logic [7:0] n_rdata, n_pd_out, n_ctl, n_wbyte;
  logic       n_rvalid, n_rev, n_irq, n_aw, n_dw, n_ar, n_dr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_ctl = 8'hC0;
  logic       exp_rev = 1'b0;
  logic [7:0] exp_data = 8'h00;
  logic [7:0] rb, nrb;
  logic       rv;

  always #5 clk = ~clk;

  pp_regif u_pp_regif (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata,
    .host_rdata, .host_rvalid, .pd_out, .pd_in, .pd_reverse, .ctl_lines,
    .status_in, .ack_evt, .irq, .epp_addr_wr, .epp_data_wr,
    .epp_addr_rd, .epp_data_rd, .epp_wbyte
  );

  pp_regif #(.BASE_ADDR(16'h3BC)) u_pp_regif_narrow (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata,
    .host_rdata(n_rdata), .host_rvalid(n_rvalid), .pd_out(n_pd_out), .pd_in,
    .pd_reverse(n_rev), .ctl_lines(n_ctl), .status_in, .ack_evt, .irq(n_irq),
    .epp_addr_wr(n_aw), .epp_data_wr(n_dw), .epp_addr_rd(n_ar),
    .epp_data_rd(n_dr), .epp_wbyte(n_wbyte)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    rb = host_rdata; nrb = n_rdata; rv = host_rvalid;
  endtask

  task automatic wctl(input logic [7:0] v, input string tag);
    logic [7:0] f;
    f = v | 8'hC0;
    wr(3'd2, v);
    if (f != exp_ctl) begin
      exp_rev = f[5];
      exp_ctl = f & 8'hDF;
    end
    chk({tag, " ctl_lines"}, ctl_lines, exp_ctl);
    chk({tag, " pd_reverse"}, {7'b0, pd_reverse}, {7'b0, exp_rev});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ctl_lines", ctl_lines, 8'hC0);
    chk("R1 pd_reverse", {7'b0, pd_reverse}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 rvalid", {7'b0, host_rvalid}, 8'h00);
    rd(3'd0);
    chk("R1 data read", rb, 8'h00);

    // R3 data write and forward readback, all byte values
    for (int i = 0; i < 256; i++) begin
      wr(3'd0, 8'(i));
      chk("R3 pd_out", pd_out, 8'(i));
      pd_in = ~8'(i);
      rd(3'd0);
      chk("R3 read", rb, 8'(i));
      chk("R2 rvalid", {7'b0, rv}, 8'h01);
    end
    exp_data = 8'hFF;

    // R5 / R6 full control sweep
    for (int v = 0; v < 256; v++) begin
      wctl(8'(v), "R5");
      rd(3'd2);
      chk("R5 ctl read", rb, exp_ctl);
    end
    // R6 equal-after-forcing write keeps reverse direction
    wctl(8'h20, "R6 setup");
    chk("R6 setup rev", {7'b0, pd_reverse}, 8'h01);
    wctl(8'h00, "R6");
    chk("R6 rev kept", {7'b0, pd_reverse}, 8'h01);
    chk("R6 ctl kept", ctl_lines, 8'hC0);

    // R4 reverse reads sample and latch the lines
    for (int i = 0; i < 16; i++) begin
      pd_in = 8'(i * 17 + 3);
      rd(3'd0);
      chk("R4 reverse read", rb, 8'(i * 17 + 3));
      exp_data = 8'(i * 17 + 3);
    end
    chk("R4 latched pd_out", pd_out, exp_data);
    wctl(8'h01, "R4 forward");
    pd_in = 8'h00;
    rd(3'd0);
    chk("R4 forward read of latched", rb, exp_data);

    // R7 status read returns lines
    for (int i = 0; i < 256; i += 17) begin
      status_in = 8'(i);
      rd(3'd1);
      chk("R7 status", rb, 8'(i));
    end

    // R8 ack ignored while disabled
    wctl(8'h00, "R8 disable");
    @(negedge clk); ack_evt = 1'b1;
    @(negedge clk); ack_evt = 1'b0;
    chk("R8 ignored", {7'b0, irq}, 8'h00);
    wctl(8'h10, "R8 enable");
    @(negedge clk); ack_evt = 1'b1;
    @(negedge clk); ack_evt = 1'b0;
    chk("R8 raised", {7'b0, irq}, 8'h01);
    rd(3'd1);
    chk("R7 cleared", {7'b0, irq}, 8'h00);
    // R8 event and status read in one cycle: event wins
    @(negedge clk); ack_evt = 1'b1; host_addr = 3'd1; host_rd = 1'b1;
    @(negedge clk); ack_evt = 1'b0; host_rd = 1'b0;
    chk("R8 event wins", {7'b0, irq}, 8'h01);
    rd(3'd1);
    chk("R7 cleared again", {7'b0, irq}, 8'h00);

    // R9 EPP writes, R11 narrow map
    for (int i = 0; i < 8; i++) begin
      wr(3'd3, 8'(i * 31));
      chk("R9 addr strobe", {6'b0, epp_addr_wr, epp_data_wr}, 8'h02);
      chk("R9 byte", epp_wbyte, 8'(i * 31));
      chk("R11 narrow offset 3", {7'b0, n_aw}, 8'h01);
      @(negedge clk);
      chk("R9 one cycle", {6'b0, epp_addr_wr, epp_data_wr}, 8'h00);
      wr(3'd4, 8'(i * 31 + 7));
      chk("R9 data strobe", {6'b0, epp_addr_wr, epp_data_wr}, 8'h01);
      chk("R9 data byte", epp_wbyte, 8'(i * 31 + 7));
      chk("R11 narrow no strobe", {7'b0, n_dw}, 8'h00);
    end

    // R10 EPP reads, R11 narrow offset 4
    for (int i = 0; i < 8; i++) begin
      pd_in = 8'(i * 29 + 5);
      rd(3'd3);
      chk("R10 addr read", rb, 8'(i * 29 + 5));
      chk("R10 addr strobe", {6'b0, epp_addr_rd, epp_data_rd}, 8'h02);
      rd(3'd4);
      chk("R10 data read", rb, 8'(i * 29 + 5));
      chk("R10 data strobe", {6'b0, epp_addr_rd, epp_data_rd}, 8'h01);
      chk("R11 narrow read", nrb, 8'hFF);
      chk("R11 narrow no rd strobe", {7'b0, n_dr}, 8'h00);
    end

    // R2 holes
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'h5A);
      chk("R2 hole pd_out", pd_out, exp_data);
      chk("R2 hole ctl", ctl_lines, exp_ctl);
      chk("R2 hole strobes", {4'b0, epp_addr_wr, epp_data_wr, epp_addr_rd, epp_data_rd}, 8'h00);
      rd(3'(a));
      chk("R2 hole read", rb, 8'hFF);
      chk("R2 hole rvalid", {7'b0, rv}, 8'h01);
      chk("R11 narrow hole read", nrb, 8'hFF);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule